// File: doc/BRIEF.md
# Stepper Phase Sequence Generator

This block turns a step clock into the polarity and enable pattern that drives the two bridges of a two-phase bipolar stepper motor. The pattern comes from a single ring of eight positions, numbered 1 to 8. Each recognised step moves the ring one position in half-step mode or two positions in full-step mode. The direction input chooses whether the ring counts up or down.

A full step keeps the parity of the current position. Starting full-step drive from an odd position therefore gives two-phase-on drive. Starting it from an even position gives one-phase-on (wave) drive. Wave drive is reached by returning home, taking one half step, and then switching to full step.

The step, direction and mode inputs may be asynchronous to the block clock. They pass through one shared synchronizer. A rising-edge detector on the step line then produces a single-cycle strobe, and the direction and mode levels are sampled on that strobe.

Top module: `stepper_seq`

## Requirements
- R1: While `rst_n` is low, and right after it is released, the ring is at position 1 and the outputs are en_a=1, pol_a=1, en_b=1, pol_b=1.
- R2: With `half_in`=1 and `dir_in`=1, each step moves the position up by one: 1,2,…,8,1.
- R3: With `half_in`=1 and `dir_in`=0, each step moves the position down by one: 1,8,7,…,2,1.
- R4: With `half_in`=0 and `dir_in`=1, each step adds two to the position, modulo 8 (7 goes to 1, 8 goes to 2).
- R5: With `half_in`=0 and `dir_in`=0, each step subtracts two from the position, modulo 8 (1 goes to 7, 2 goes to 8).
- R6: The outputs {en_a,pol_a,en_b,pol_b} for positions 1 to 8 are, in that order: 1111, 0011, 1011, 1000, 1010, 0010, 1110, 1100.
- R7: At least one enable is high at all times. Odd positions drive both bridges and even positions drive exactly one.
- R8: After reset, one half step reaches position 2 (clockwise) or position 8 (counterclockwise). Full steps taken from there stay on even positions, which gives wave drive.
- R9: Only a rising edge on `step_in` changes the position. The new outputs appear after the third rising `clk` edge that follows the edge, counting from the first edge that samples the new level (SYNC_STAGES+1 edges). Holding `step_in` high or lowering it has no effect.
- R10: A change of `dir_in` or `half_in` between steps leaves the outputs unchanged until the next step. A change presented at the same time as the step edge applies to that step.
- R11: In full-step mode the parity of the position never changes, so normal drive started from an odd position stays on odd positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; returns the ring to position 1 |
| step_in | input | 1 | Step clock; a rising edge advances the ring (asynchronous) |
| dir_in | input | 1 | Direction: 1 clockwise (count up), 0 counterclockwise (asynchronous) |
| half_in | input | 1 | 1 selects half step, 0 selects full step (asynchronous) |
| pol_a | output | 1 | Bridge A polarity |
| en_a | output | 1 | Bridge A enable |
| pol_b | output | 1 | Bridge B polarity |
| en_b | output | 1 | Bridge B enable |

## Verification
The step strobe and a change of direction or mode can land in the same cycle. All three lines share one synchronizer, so in that case the strobe must use the new levels. The bench provokes this by changing `dir_in` and `half_in` on the same clock edge that raises `step_in`, for example reversing direction and switching between half and full step in mid-sequence. The scoreboard expects the position computed with the new setting. It also checks that the outputs still show the old position two edges after the change, and the new position after the third edge.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
   localparam int RING_LEN = 8;
   localparam int IDX_W    = $clog2(RING_LEN);

   typedef logic [IDX_W-1:0] ring_idx_t;

   typedef struct packed {
      logic en_a;
      logic pol_a;
      logic en_b;
      logic pol_b;
   } coil_drive_t;

   // index 0 is position 1 (home)
   function automatic coil_drive_t drive_of(ring_idx_t i);
      coil_drive_t d;
      case (i)
         3'd0:    d = '{1'b1, 1'b1, 1'b1, 1'b1};
         3'd1:    d = '{1'b0, 1'b0, 1'b1, 1'b1};
         3'd2:    d = '{1'b1, 1'b0, 1'b1, 1'b1};
         3'd3:    d = '{1'b1, 1'b0, 1'b0, 1'b0};
         3'd4:    d = '{1'b1, 1'b0, 1'b1, 1'b0};
         3'd5:    d = '{1'b0, 1'b0, 1'b1, 1'b0};
         3'd6:    d = '{1'b1, 1'b1, 1'b1, 1'b0};
         default: d = '{1'b1, 1'b1, 1'b0, 1'b0};
      endcase
      return d;
   endfunction
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] pipe [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) pipe[s] <= '0;
      end else begin
         pipe[0] <= d;
         for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/rise_detect.sv
module rise_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic pulse
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl;
   end

   assign pulse = lvl & ~lvl_q;
endmodule

// File: rtl/phase_ring.sv
module phase_ring
   import stepper_pkg::*;
#(
   parameter ring_idx_t HOME = '0
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      adv,
   input  logic      fine,
   input  logic      fwd,
   output ring_idx_t idx
);
   ring_idx_t stride;
   ring_idx_t idx_nxt;

   always_comb begin
      stride  = fine ? ring_idx_t'(1) : ring_idx_t'(2);
      idx_nxt = fwd ? ring_idx_t'(idx + stride) : ring_idx_t'(idx - stride);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   idx <= HOME;
      else if (adv) idx <= idx_nxt;
   end
endmodule

// File: rtl/phase_decode.sv
module phase_decode
   import stepper_pkg::*;
#(
   parameter bit        REG_OUT = 1'b0,
   parameter ring_idx_t HOME    = '0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  ring_idx_t   idx,
   output coil_drive_t drive
);
   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) drive <= drive_of(HOME);
            else        drive <= drive_of(idx);
         end
      end else begin : g_comb
         always_comb drive = drive_of(idx);
      end
   endgenerate
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
   import stepper_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit REG_OUT     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_in,
   input  logic dir_in,
   input  logic half_in,
   output logic pol_a,
   output logic en_a,
   output logic pol_b,
   output logic en_b
);
   localparam int        SYNC_W = 3;
   localparam ring_idx_t HOME   = '0;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("stepper_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_W-1:0] raw_v;
   logic [SYNC_W-1:0] syn_v;
   logic              step_s;
   logic              dir_s;
   logic              half_s;
   logic              step_stb;
   ring_idx_t         state_idx;
   coil_drive_t       drv;

   assign raw_v = {step_in, dir_in, half_in};

   sync_bank #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_v),
      .q    (syn_v)
   );

   assign {step_s, dir_s, half_s} = syn_v;

   rise_detect u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (step_s),
      .pulse(step_stb)
   );

   phase_ring #(.HOME(HOME)) u_ring (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (step_stb),
      .fine (half_s),
      .fwd  (dir_s),
      .idx  (state_idx)
   );

   phase_decode #(.REG_OUT(REG_OUT), .HOME(HOME)) u_dec (
      .clk  (clk),
      .rst_n(rst_n),
      .idx  (state_idx),
      .drive(drv)
   );

   assign en_a  = drv.en_a;
   assign pol_a = drv.pol_a;
   assign en_b  = drv.en_b;
   assign pol_b = drv.pol_b;
endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk
   import stepper_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      strobe,
   input logic      half_s,
   input logic      dir_s,
   input ring_idx_t idx,
   input logic      en_a,
   input logic      en_b
);
   assert_enable_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a || en_b));

   assert_hold_no_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(idx));

   assert_half_cw_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && half_s && dir_s) |=> idx == ring_idx_t'($past(idx) + 3'd1));

   assert_half_ccw_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && half_s && !dir_s) |=> idx == ring_idx_t'($past(idx) - 3'd1));

   assert_full_cw_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !half_s && dir_s) |=> idx == ring_idx_t'($past(idx) + 3'd2));

   assert_full_ccw_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !half_s && !dir_s) |=> idx == ring_idx_t'($past(idx) - 3'd2));

   assert_parity_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !half_s) |=> idx[0] == $past(idx[0]));
endmodule

bind stepper_seq stepper_seq_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .strobe(step_stb),
   .half_s(half_s),
   .dir_s (dir_s),
   .idx   (state_idx),
   .en_a  (en_a),
   .en_b  (en_b)
);

// File: tb/sim_stepper_seq.sv
`timescale 1ns/1ps
module sim_stepper_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic step_in = 1'b0;
   logic dir_in = 1'b1;
   logic half_in = 1'b1;
   logic pol_a, en_a, pol_b, en_b;

   int n_chk = 0;
   int n_fail = 0;
   int cur = 1;
   bit done = 1'b0;

   logic [3:0] exp_q[$];
   string      tag_q[$];
   event       chk_ev;

   always #2 clk = ~clk;

   stepper_seq u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_in(step_in),
      .dir_in (dir_in),
      .half_in(half_in),
      .pol_a  (pol_a),
      .en_a   (en_a),
      .pol_b  (pol_b),
      .en_b   (en_b)
   );

   // R6 table, {en_a,pol_a,en_b,pol_b}
   function automatic logic [3:0] exp_drive(int s);
      case (s)
         1: return 4'b1111;
         2: return 4'b0011;
         3: return 4'b1011;
         4: return 4'b1000;
         5: return 4'b1010;
         6: return 4'b0010;
         7: return 4'b1110;
         default: return 4'b1100;
      endcase
   endfunction

   function automatic int next_pos(int s, logic dir, logic half);
      if (half) return dir ? (s % 8) + 1 : ((s + 6) % 8) + 1;
      else      return dir ? ((s + 1) % 8) + 1 : ((s + 5) % 8) + 1;
   endfunction

   function automatic logic [3:0] outs();
      return {en_a, pol_a, en_b, pol_b};
   endfunction

   task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // monitor: pops expected items and compares
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, outs(), e);
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      step_in = 1'b0;
      #1;
      check("R1 during reset", outs(), 4'b1111);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur = 1;
      repeat (4) @(negedge clk);
      check("R1 after reset", outs(), exp_drive(1));
   endtask

   // driver: one step, new levels presented with the step edge (R10)
   task automatic do_step(logic dir, logic half, string tag);
      logic [3:0] old_v;
      old_v = exp_drive(cur);
      @(negedge clk);
      dir_in = dir;
      half_in = half;
      step_in = 1'b1;
      cur = next_pos(cur, dir, half);
      exp_q.push_back(exp_drive(cur));
      tag_q.push_back(tag);
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R9 latency hold", outs(), old_v);
      @(posedge clk); @(negedge clk);
      -> chk_ev;
      repeat (3) @(negedge clk);
      step_in = 1'b0;
      repeat (5) @(negedge clk);
      check("R9 level/fall no effect", outs(), exp_drive(cur));
   endtask

   initial begin
      do_reset();

      for (int i = 0; i < 8; i++) do_step(1'b1, 1'b1, "R2 half cw");
      for (int i = 0; i < 8; i++) do_step(1'b0, 1'b1, "R3 half ccw");

      do_reset();
      for (int i = 0; i < 5; i++) do_step(1'b1, 1'b0, "R4 R11 full cw normal");
      for (int i = 0; i < 5; i++) do_step(1'b0, 1'b0, "R5 R11 full ccw normal");

      do_reset();
      do_step(1'b1, 1'b1, "R8 half cw to 2");
      check("R8 reached position 2", outs(), exp_drive(2));
      for (int i = 0; i < 5; i++) do_step(1'b1, 1'b0, "R8 wave cw");
      for (int i = 0; i < 3; i++) do_step(1'b0, 1'b0, "R8 wave ccw");

      do_reset();
      do_step(1'b0, 1'b1, "R8 half ccw to 8");
      check("R8 reached position 8", outs(), exp_drive(8));
      for (int i = 0; i < 4; i++) do_step(1'b0, 1'b0, "R8 wave ccw from 8");

      // R10: change levels with no step, outputs must not move
      @(negedge clk);
      dir_in = ~dir_in;
      half_in = ~half_in;
      repeat (10) @(negedge clk);
      check("R10 level change without step", outs(), exp_drive(cur));
      dir_in = ~dir_in;
      repeat (10) @(negedge clk);
      check("R10 second change without step", outs(), exp_drive(cur));

      // R10 same-cycle change: reverse direction and mode on the step edge
      do_step(1'b1, 1'b1, "R10 same-cycle half cw");
      do_step(1'b0, 1'b0, "R10 same-cycle full ccw");
      do_step(1'b1, 1'b1, "R10 same-cycle half cw again");

      // R1: reset in mid-run returns home
      do_step(1'b1, 1'b1, "R2 before mid reset");
      do_reset();
      do_step(1'b1, 1'b0, "R4 after mid reset");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule